// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a small synchronous up-counter with a 4-bit state by default. All state bits update together on the rising clock edge. The counter can be cleared at once from an active-low clear input. It can be preset from a data input through an active-low load strobe. It counts only when two active-high enables are both high: a count enable and a carry enable.

The terminal-count output is combinational. It is high when the state is all ones and the carry enable is high. The count enable has no effect on it. Because of this, a chain of stages counts in lock step. Each stage's terminal count drives the carry enable of the stage above it. All stages share one count enable. The upper stage advances on the same edge on which the lower stage wraps.

The clear takes effect at once when it asserts. Its release passes through a short synchroniser inside the block, so the first clock edges after release never see a half-released reset.

Top module: `pcnt_cascadable`

## Requirements
- R1: While `clr_ni` is low, `count_o` is 0. It becomes 0 as soon as `clr_ni` falls, with no clock edge needed, whatever the load, data and enable inputs are.
- R2: While `clr_ni` is low, `term_o` is 0, even when `carry_en_i` is high.
- R3: After `clr_ni` rises, the first SYNC_STAGES (default 2) rising edges leave `count_o` at 0 whatever the other inputs are. The next edge is the first to act.
- R4: At a rising edge with `load_ni` low, `count_o` takes the value of `data_i`, whatever the levels of `cnt_en_i` and `carry_en_i`.
- R5: At a rising edge with `load_ni` high and both `cnt_en_i` and `carry_en_i` high, `count_o` increases by one.
- R6: At a rising edge with `load_ni` high and either enable low, `count_o` keeps its value.
- R7: `term_o` is 1 exactly when `carry_en_i` is 1 and `count_o` is all ones (15). It follows `carry_en_i` without waiting for a clock edge, and `cnt_en_i` has no effect on it.
- R8: An increment from all ones (15) gives 0.
- R9: With two stages chained, where the lower stage's `term_o` drives the upper stage's `carry_en_i` and both share `cnt_en_i`, the pair counts 0 to 255 in steps of one and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the state updates on the rising edge |
| clr_ni | input | 1 | Clear, active low; asserts at once, release is synchronised |
| load_ni | input | 1 | Synchronous preset strobe, active low |
| data_i | input | WIDTH | Preset value |
| cnt_en_i | input | 1 | Count enable; does not gate the terminal count |
| carry_en_i | input | 1 | Carry enable; gates counting and the terminal count |
| count_o | output | WIDTH | Counter state |
| term_o | output | 1 | Terminal count: all ones and carry enable high |

## Verification
Every preset value from 0 to 15 is loaded while the two enables step through all four level combinations. This shows that a load overrides the enables, and it checks the terminal count at every state with both carry-enable levels. A two-stage chain then counts through all 256 values and one wrap. Each step is compared with the step number modulo 256, so a missing carry, a double carry or a wrong wrap gives a clear mismatch. Hold patterns with each enable dropped in turn, a clear asserted in mid-cycle, and loads offered during the release window separate the hold, clear and synchroniser behaviour from counting.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2
  } pcnt_mode_e;
endpackage

// File: rtl/pcnt_rst_sync.sv
module pcnt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic clr_ni,
  output logic rst_no
);
  generate
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) stage_q <= 1'b0;
        else         stage_q <= 1'b1;
      end
      assign rst_no = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] shift_q;
      always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) shift_q <= '0;
        else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
      end
      assign rst_no = shift_q[STAGES-1];
    end
  endgenerate

  // R1: the internal reset must follow the clear low at every sampled edge
  a_r1_sync_follows_clear: assert property (@(posedge clk_i)
    !clr_ni |-> !rst_no);
endmodule

// File: rtl/pcnt_mode_dec.sv
module pcnt_mode_dec
  import pcnt_pkg::*;
(
  input  logic       load_ni,
  input  logic       cnt_en_i,
  input  logic       carry_en_i,
  output pcnt_mode_e mode_o
);
  always_comb begin
    if (!load_ni)                     mode_o = MODE_LOAD;
    else if (cnt_en_i && carry_en_i)  mode_o = MODE_COUNT;
    else                              mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/pcnt_state.sv
module pcnt_state
  import pcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pcnt_mode_e       mode_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] state_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
    end else begin
      unique case (mode_i)
        MODE_LOAD:  state_q <= data_i;
        MODE_COUNT: state_q <= state_q + ONE;
        default:    state_q <= state_q;
      endcase
    end
  end

  assign state_o = state_q;

  // R4: preset captures the data input
  a_r4_load_takes_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOAD) |=> (state_o == $past(data_i)));
  // R5/R8: increment by one, modulo 2**WIDTH
  a_r5_count_steps_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_COUNT) |=> (state_o == WIDTH'($past(state_o) + ONE)));
  // R6: hold keeps the state
  a_r6_hold_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HOLD) |=> $stable(state_o));
endmodule

// File: rtl/pcnt_tc.sv
module pcnt_tc #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] state_i,
  input  logic             carry_en_i,
  output logic             term_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  assign term_o = rst_ni & carry_en_i & (state_i == ALL_ONES);

  // R7: terminal count needs the carry enable
  a_r7_tc_needs_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |-> carry_en_i);
  // R7: terminal count only at all ones
  a_r7_tc_only_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ALL_ONES) |-> !term_o);
endmodule

// File: rtl/pcnt_cascadable.sv
module pcnt_cascadable
  import pcnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             cnt_en_i,
  input  logic             carry_en_i,
  output logic [WIDTH-1:0] count_o,
  output logic             term_o
);
  logic       rst_sync_n;
  pcnt_mode_e mode;

  pcnt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .clr_ni (clr_ni),
    .rst_no (rst_sync_n)
  );

  pcnt_mode_dec u_mode_dec (
    .load_ni    (load_ni),
    .cnt_en_i   (cnt_en_i),
    .carry_en_i (carry_en_i),
    .mode_o     (mode)
  );

  pcnt_state #(.WIDTH(WIDTH)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .mode_i  (mode),
    .data_i  (data_i),
    .state_o (count_o)
  );

  pcnt_tc #(.WIDTH(WIDTH)) u_tc (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .state_i    (count_o),
    .carry_en_i (carry_en_i),
    .term_o     (term_o)
  );

  // R1: state is zero whenever the clear is low
  a_r1_clear_zeroes: assert property (@(posedge clk_i)
    !clr_ni |-> (count_o == '0));
  // R2: no terminal count during clear
  a_r2_clear_no_tc: assert property (@(posedge clk_i)
    !clr_ni |-> !term_o);
  // R3: while the release is still in the synchroniser the state stays zero
  a_r3_release_window_zero: assert property (@(posedge clk_i) disable iff (!clr_ni)
    !rst_sync_n |-> (count_o == '0));
endmodule

// File: tb/tb_pcnt_cascadable.sv
`timescale 1ns/1ps
module tb_pcnt_cascadable;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         load_n = 1'b1;
  logic [W-1:0] data_lo = '0;
  logic [W-1:0] data_hi = '0;
  logic         en_p = 1'b0;
  logic         en_t = 1'b0;
  logic [W-1:0] q_lo, q_hi;
  logic         tc_lo, tc_hi;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcnt_cascadable #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .clr_ni(clr_n), .load_ni(load_n), .data_i(data_lo),
    .cnt_en_i(en_p), .carry_en_i(en_t), .count_o(q_lo), .term_o(tc_lo));

  pcnt_cascadable #(.WIDTH(W), .SYNC_STAGES(2)) u_hi (
    .clk_i(clk), .clr_ni(clr_n), .load_ni(load_n), .data_i(data_hi),
    .cnt_en_i(en_p), .carry_en_i(tc_lo), .count_o(q_hi), .term_o(tc_hi));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_clear();
    clr_n = 1'b1;
    tick();
    tick();
  endtask

  initial begin
    @(negedge clk);
    en_t = 1'b1; en_p = 1'b1; load_n = 1'b0; data_lo = 4'd15;
    tick(); tick();
    // R1 / R2 reset state with every other input active
    chk("R1 reset lo", q_lo, 0);
    chk("R1 reset hi", q_hi, 0);
    chk("R2 tc low in clear", tc_lo, 0);

    // R3: load offered throughout the release window
    data_lo = 4'd5; data_hi = 4'd9;
    clr_n = 1'b1;
    tick(); chk("R3 edge1 ignored", q_lo, 0);
    tick(); chk("R3 edge2 ignored", q_lo, 0);
    tick(); chk("R3 edge3 loads lo", q_lo, 5);
    chk("R3 edge3 loads hi", q_hi, 9);

    // R1: asynchronous clear in mid-cycle
    load_n = 1'b1;
    #2 clr_n = 1'b0;
    #1 chk("R1 async clear lo", q_lo, 0);
    chk("R1 async clear hi", q_hi, 0);
    @(negedge clk);
    en_p = 1'b0; en_t = 1'b0;
    release_clear();

    // R4 / R7: load sweep with all enable combinations
    for (int v = 0; v < 16; v++) begin
      load_n = 1'b0; data_lo = 4'(v); data_hi = 4'(15 - v);
      en_p = v[0]; en_t = v[1];
      tick();
      chk("R4 load lo", q_lo, v);
      chk("R4 load hi", q_hi, 15 - v);
      chk("R7 tc vs state and carry", tc_lo, (v[1] && v == 15) ? 1 : 0);
    end

    // R7: count enable does not gate tc; carry enable gates it without an edge
    load_n = 1'b0; data_lo = 4'd15; data_hi = 4'd3; tick();
    load_n = 1'b1; en_p = 1'b0; en_t = 1'b1;
    #1 chk("R7 tc with cnt_en low", tc_lo, 1);
    en_t = 1'b0;
    #1 chk("R7 tc drops with carry", tc_lo, 0);
    @(negedge clk);
    // R6: hold with each enable low
    en_p = 1'b1; en_t = 1'b0;
    tick(); tick();
    chk("R6 hold carry low lo", q_lo, 15);
    chk("R6 hold carry low hi", q_hi, 3);
    en_p = 1'b0; en_t = 1'b1;
    tick(); tick();
    chk("R6 hold cnt low lo", q_lo, 15);
    chk("R6 hold cnt low hi", q_hi, 3);

    // R8: single wrap 15 -> 0, upper stage advances on the same edge
    en_p = 1'b1;
    tick();
    chk("R8 wrap lo", q_lo, 0);
    chk("R9 carry into hi", q_hi, 4);
    tick();
    chk("R5 increment", q_lo, 1);

    // R9: full cascade sweep 0..255 and wrap
    load_n = 1'b0; data_lo = '0; data_hi = '0; tick();
    load_n = 1'b1;
    for (int i = 1; i <= 260; i++) begin
      tick();
      chk("R9 cascade value", q_hi * 16 + q_lo, i % 256);
      chk("R7 tc lo in sweep", tc_lo, (q_lo == 15) ? 1 : 0);
      chk("R9 tc hi in sweep", tc_hi, (q_lo == 15 && q_hi == 15) ? 1 : 0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule